// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the bookkeeping for a circular queue of descriptors shared between a software producer and a DMA engine. Software chooses the descriptor format (small or large entries), sets how many entries the ring holds, and then works only in counts. It posts a batch of new descriptors by writing how many were added, and it hands a batch of finished descriptors back by writing how many it has consumed. The block never takes a pointer from software.

Three indices move around the ring: the execute index (next descriptor the engine will take), the done index (oldest finished descriptor software has not yet released) and the posted limit (one past the last posted descriptor). A simple ready/valid execution port stands in for the engine. Each handshake consumes and completes one descriptor. A status word reports the finished-but-unreleased count together with the done index. A halt control stops the engine from taking descriptors.

Requests that would overfill the ring or release more than has finished are trimmed to what is legal, and a sticky error flag records that this happened.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset the engine is halted, the ring holds RST_ENTRIES (1024) entries in large-descriptor format, every index and count is zero, exec_valid is 0 and err_flag is 0.
- R2: A format write with code 1 selects small descriptors with a cap of 2^14 entries. Code 7 selects large descriptors with a cap of 2^12 entries. Any other code is ignored: ring size, indices and counts stay unchanged.
- R3: A ring-size write sets the wrap point. The value is clamped to at least 1 and at most the cap of the current format. A format write re-clamps the stored size. Any accepted size or format write returns all indices and counts to zero.
- R4: A post write of N adds N to the available count and advances post_ptr by N. exec_valid is 1 only when the engine is running and the available count is nonzero, so the execute index never passes the posted limit.
- R5: A halt write with value 1 stops the engine and value 0 restarts it. While halted, exec_valid is 0 and the execute index holds.
- R6: Each cycle with exec_valid and exec_ready both 1 lowers the available count by one, advances the execute index by one, and raises the finished count by one.
- R7: A release write of N lowers the finished count by N and advances the done index by N.
- R8: status_word carries the finished count in bits [14:0] and the low 13 bits of the done index in bits [28:16]. All other bits are 0.
- R9: The execute index, the done index and the posted limit each wrap to zero on reaching the ring size.
- R10: A post larger than the free room (ring size minus available minus finished, taken before the cycle) is cut to that room and sets err_flag. err_flag stays set until reset.
- R11: A release larger than the finished count before the cycle is cut to that count and sets err_flag.
- R12: A post or release in the same cycle as a handshake completion applies both changes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_wr | input | 1 | Ring-size write strobe |
| size_val | input | 16 | Requested entry count |
| dsz_wr | input | 1 | Descriptor-format write strobe |
| dsz_val | input | 3 | Format code: 1 small, 7 large |
| halt_wr | input | 1 | Halt-control write strobe |
| halt_val | input | 1 | 1 halts the engine, 0 runs it |
| post_wr | input | 1 | Post-count write strobe |
| post_cnt | input | 16 | Number of descriptors posted |
| free_wr | input | 1 | Release-count write strobe |
| free_cnt | input | 16 | Number of finished descriptors released |
| exec_valid | output | 1 | A posted descriptor is ready for the engine |
| exec_ready | input | 1 | Engine takes and finishes the offered descriptor |
| exec_idx | output | 14 | Execute index |
| ring_entries | output | 15 | Effective ring size |
| done_ptr | output | 14 | Done index |
| post_ptr | output | 14 | Posted limit index |
| avail_cnt | output | 15 | Posted but not yet executed count |
| status_word | output | 32 | Finished count and done index |
| halted | output | 1 | Engine halted |
| err_flag | output | 1 | Sticky clamp error |

## Verification
The bench targets the wrap of every index at a small ring size. A design that compares against the wrong bound would show an execute index of 8 or a done index of 9 instead of 0 and 1. It posts into a nearly full ring and releases more than has finished. A design without clamping would let the counts wrap and leave err_flag low. It also places a release and a completion in the same cycle, where a design that drops one of the two changes leaves the finished count off by one. Finally, it checks that a size write clamps to the cap of the format picked in the same cycle, and that an unknown format code does not disturb the posted count.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam logic [2:0] DSZ_CODE_SMALL = 3'd1;
  localparam logic [2:0] DSZ_CODE_LARGE = 3'd7;
  localparam int STAT_CNT_W = 15;
  localparam int STAT_PTR_W = 13;
endpackage

// File: rtl/ring_cfg.sv
module ring_cfg
  import desc_ring_pkg::*;
#(
  parameter int LOG_SMALL   = 14,
  parameter int LOG_LARGE   = 12,
  parameter int RST_ENTRIES = 1024,
  parameter int SZ_W        = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 size_wr,
  input  logic [SZ_W-1:0]      size_val,
  input  logic                 dsz_wr,
  input  logic [2:0]           dsz_val,
  input  logic                 halt_wr,
  input  logic                 halt_val,
  output logic [LOG_SMALL:0]   entries_o,
  output logic                 halted_o,
  output logic                 clear_o
);
  localparam int EW = LOG_SMALL + 1;
  localparam int CW = (SZ_W > EW) ? SZ_W : EW;
  localparam logic [EW-1:0] MAX_SMALL = {1'b1, {LOG_SMALL{1'b0}}};
  localparam logic [EW-1:0] MAX_LARGE = EW'({1'b1, {LOG_LARGE{1'b0}}});

  logic          large_q, large_n, dsz_ok, halted_q;
  logic [EW-1:0] entries_q, entries_n, cap;
  logic [CW-1:0] req;

  assign dsz_ok  = dsz_wr && ((dsz_val == DSZ_CODE_SMALL) || (dsz_val == DSZ_CODE_LARGE));
  assign large_n = dsz_ok ? (dsz_val == DSZ_CODE_LARGE) : large_q;
  assign cap     = large_n ? MAX_LARGE : MAX_SMALL;
  assign req     = size_wr ? CW'(size_val) : CW'(entries_q);

  always_comb begin
    if (req == '0)            entries_n = EW'(1);
    else if (req > CW'(cap))  entries_n = cap;
    else                      entries_n = EW'(req);
  end

  assign clear_o   = size_wr || dsz_ok;
  assign entries_o = entries_q;
  assign halted_o  = halted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      large_q   <= 1'b1;
      entries_q <= EW'(RST_ENTRIES);
      halted_q  <= 1'b1;
    end else begin
      if (clear_o) entries_q <= entries_n;
      large_q <= large_n;
      if (halt_wr) halted_q <= halt_val;
    end
  end

  // R3: the wrap point always lies between 1 and the cap of the format in force
  assert_entries_range_R3: assert property (@(posedge clk) disable iff (rst)
    (entries_q != '0) && (entries_q <= (large_q ? MAX_LARGE : MAX_SMALL)));
endmodule

// File: rtl/ring_wrap_ptr.sv
module ring_wrap_ptr #(
  parameter int PTR_W = 14,
  parameter int EW    = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [EW-1:0]    entries,
  input  logic [EW-1:0]    step,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [EW:0]      sum, lim;

  assign sum   = {2'b00, ptr_q} + {1'b0, step};
  assign lim   = {1'b0, entries};
  assign ptr_o = ptr_q;

  always_ff @(posedge clk) begin
    if (rst || clear) ptr_q <= '0;
    else              ptr_q <= PTR_W'((sum >= lim) ? (sum - lim) : sum);
  end

  // R9: an index never reaches the ring size
  assert_ptr_bound_R9: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ptr_q} < entries);
endmodule

// File: rtl/ring_counts.sv
module ring_counts #(
  parameter int EW    = 15,
  parameter int REQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             halted,
  input  logic [EW-1:0]    entries,
  input  logic             post_wr,
  input  logic [REQ_W-1:0] post_cnt,
  input  logic             free_wr,
  input  logic [REQ_W-1:0] free_cnt,
  input  logic             exec_ready,
  output logic             exec_valid,
  output logic             fire,
  output logic [EW-1:0]    avail_o,
  output logic [EW-1:0]    done_o,
  output logic [EW-1:0]    post_g,
  output logic [EW-1:0]    free_g,
  output logic             err_o
);
  localparam int W = (REQ_W > EW + 1) ? REQ_W : EW + 1;

  logic [EW-1:0] avail_q, done_q;
  logic [W-1:0]  room, pc, fc;
  logic          post_over, free_over, err_q;

  assign room      = W'(entries) - W'(avail_q) - W'(done_q);
  assign pc        = W'(post_cnt);
  assign fc        = W'(free_cnt);
  assign post_over = post_wr && !clear && (pc > room);
  assign free_over = free_wr && !clear && (fc > W'(done_q));

  always_comb begin
    post_g = '0;
    free_g = '0;
    if (post_wr && !clear) post_g = post_over ? EW'(room) : EW'(pc);
    if (free_wr && !clear) free_g = free_over ? done_q : EW'(fc);
  end

  assign exec_valid = !halted && (avail_q != '0);
  assign fire       = exec_valid && exec_ready;
  assign avail_o    = avail_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= '0;
      done_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (clear) begin
        avail_q <= '0;
        done_q  <= '0;
      end else begin
        avail_q <= avail_q + post_g - EW'(fire);
        done_q  <= done_q + EW'(fire) - free_g;
      end
      if (post_over || free_over) err_q <= 1'b1;
    end
  end

  // R10: posted plus finished never exceeds the ring
  assert_no_overfill_R10: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, avail_q} + {1'b0, done_q}) <= {1'b0, entries});
  // R10: the error flag is sticky
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R11: releasing everything or more leaves only this cycle's completion
  assert_free_clamp_R11: assert property (@(posedge clk) disable iff (rst)
    (free_wr && !clear && (fc >= W'(done_q))) |=> (done_q == EW'($past(fire))));
endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
  import desc_ring_pkg::*;
#(
  parameter int LOG_SMALL   = 14,
  parameter int LOG_LARGE   = 12,
  parameter int RST_ENTRIES = 1024,
  parameter int REQ_W       = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 size_wr,
  input  logic [REQ_W-1:0]     size_val,
  input  logic                 dsz_wr,
  input  logic [2:0]           dsz_val,
  input  logic                 halt_wr,
  input  logic                 halt_val,
  input  logic                 post_wr,
  input  logic [REQ_W-1:0]     post_cnt,
  input  logic                 free_wr,
  input  logic [REQ_W-1:0]     free_cnt,
  output logic                 exec_valid,
  input  logic                 exec_ready,
  output logic [LOG_SMALL-1:0] exec_idx,
  output logic [LOG_SMALL:0]   ring_entries,
  output logic [LOG_SMALL-1:0] done_ptr,
  output logic [LOG_SMALL-1:0] post_ptr,
  output logic [LOG_SMALL:0]   avail_cnt,
  output logic [31:0]          status_word,
  output logic                 halted,
  output logic                 err_flag
);
  localparam int PTR_W = LOG_SMALL;
  localparam int EW    = LOG_SMALL + 1;

  logic          cfg_clear, fire;
  logic [EW-1:0] done_cnt, post_g, free_g;

  ring_cfg #(
    .LOG_SMALL(LOG_SMALL), .LOG_LARGE(LOG_LARGE),
    .RST_ENTRIES(RST_ENTRIES), .SZ_W(REQ_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .size_wr(size_wr), .size_val(size_val),
    .dsz_wr(dsz_wr), .dsz_val(dsz_val), .halt_wr(halt_wr), .halt_val(halt_val),
    .entries_o(ring_entries), .halted_o(halted), .clear_o(cfg_clear)
  );

  ring_counts #(.EW(EW), .REQ_W(REQ_W)) u_counts (
    .clk(clk), .rst(rst), .clear(cfg_clear), .halted(halted),
    .entries(ring_entries), .post_wr(post_wr), .post_cnt(post_cnt),
    .free_wr(free_wr), .free_cnt(free_cnt), .exec_ready(exec_ready),
    .exec_valid(exec_valid), .fire(fire), .avail_o(avail_cnt), .done_o(done_cnt),
    .post_g(post_g), .free_g(free_g), .err_o(err_flag)
  );

  ring_wrap_ptr #(.PTR_W(PTR_W), .EW(EW)) u_exec_ptr (
    .clk(clk), .rst(rst), .clear(cfg_clear), .entries(ring_entries),
    .step(EW'(fire)), .ptr_o(exec_idx)
  );

  ring_wrap_ptr #(.PTR_W(PTR_W), .EW(EW)) u_done_ptr (
    .clk(clk), .rst(rst), .clear(cfg_clear), .entries(ring_entries),
    .step(free_g), .ptr_o(done_ptr)
  );

  ring_wrap_ptr #(.PTR_W(PTR_W), .EW(EW)) u_post_ptr (
    .clk(clk), .rst(rst), .clear(cfg_clear), .entries(ring_entries),
    .step(post_g), .ptr_o(post_ptr)
  );

  assign status_word = {3'b000, STAT_PTR_W'(done_ptr), 1'b0, STAT_CNT_W'(done_cnt)};

  // Cross-checks between the separately kept indices and counts
  logic [EW:0] done_sum, post_sum, lim;
  assign lim      = {1'b0, ring_entries};
  assign done_sum = {2'b00, done_ptr} + {1'b0, done_cnt};
  assign post_sum = {2'b00, exec_idx} + {1'b0, avail_cnt};

  // R7: done index plus finished count lands on the execute index
  assert_done_track_R7: assert property (@(posedge clk) disable iff (rst)
    PTR_W'((done_sum >= lim) ? (done_sum - lim) : done_sum) == exec_idx);
  // R4: execute index plus available count lands on the posted limit
  assert_post_limit_R4: assert property (@(posedge clk) disable iff (rst)
    PTR_W'((post_sum >= lim) ? (post_sum - lim) : post_sum) == post_ptr);
  // R5: a halted engine does not move the execute index
  assert_halt_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (halted && !cfg_clear) |=> (exec_idx == $past(exec_idx)));
endmodule

// File: tb/desc_ring_tracker_tb.sv
module desc_ring_tracker_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        size_wr = 0, dsz_wr = 0, halt_wr = 0, halt_val = 0;
  logic        post_wr = 0, free_wr = 0, exec_ready = 0;
  logic [15:0] size_val = 0, post_cnt = 0, free_cnt = 0;
  logic [2:0]  dsz_val = 0;
  logic        exec_valid, halted, err_flag;
  logic [13:0] exec_idx, done_ptr, post_ptr;
  logic [14:0] ring_entries, avail_cnt;
  logic [31:0] status_word;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  desc_ring_tracker u_dut (
    .clk(clk), .rst(rst), .size_wr(size_wr), .size_val(size_val),
    .dsz_wr(dsz_wr), .dsz_val(dsz_val), .halt_wr(halt_wr), .halt_val(halt_val),
    .post_wr(post_wr), .post_cnt(post_cnt), .free_wr(free_wr), .free_cnt(free_cnt),
    .exec_valid(exec_valid), .exec_ready(exec_ready), .exec_idx(exec_idx),
    .ring_entries(ring_entries), .done_ptr(done_ptr), .post_ptr(post_ptr),
    .avail_cnt(avail_cnt), .status_word(status_word), .halted(halted),
    .err_flag(err_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven; sample 1 unit after the edge, then drop strobes
  task automatic step();
    @(posedge clk);
    #1;
    size_wr = 0; dsz_wr = 0; halt_wr = 0; post_wr = 0; free_wr = 0; exec_ready = 0;
  endtask

  // {post_wr, post_cnt, free_wr, free_cnt, ready, avail, done, done_ptr, exec, post_ptr, err}
  localparam logic [59:0] VEC [0:14] = '{
    {1'b1, 8'd5, 1'b0, 8'd0, 1'b0, 8'd5, 8'd0, 8'd0, 8'd0, 8'd5, 1'b0},
    {1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd4, 8'd1, 8'd0, 8'd1, 8'd5, 1'b0},
    {1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd3, 8'd2, 8'd0, 8'd2, 8'd5, 1'b0},
    {1'b0, 8'd0, 1'b1, 8'd1, 1'b1, 8'd2, 8'd2, 8'd1, 8'd3, 8'd5, 1'b0},
    {1'b1, 8'd4, 1'b0, 8'd0, 1'b0, 8'd6, 8'd2, 8'd1, 8'd3, 8'd1, 1'b0},
    {1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd5, 8'd3, 8'd1, 8'd4, 8'd1, 1'b0},
    {1'b0, 8'd0, 1'b1, 8'd3, 1'b0, 8'd5, 8'd0, 8'd4, 8'd4, 8'd1, 1'b0},
    {1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd4, 8'd1, 8'd4, 8'd5, 8'd1, 1'b0},
    {1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd3, 8'd2, 8'd4, 8'd6, 8'd1, 1'b0},
    {1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd2, 8'd3, 8'd4, 8'd7, 8'd1, 1'b0},
    {1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd1, 8'd4, 8'd4, 8'd0, 8'd1, 1'b0},
    {1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd0, 8'd5, 8'd4, 8'd1, 8'd1, 1'b0},
    {1'b0, 8'd0, 1'b0, 8'd0, 1'b1, 8'd0, 8'd5, 8'd4, 8'd1, 8'd1, 1'b0},
    {1'b1, 8'd5, 1'b0, 8'd0, 1'b0, 8'd3, 8'd5, 8'd4, 8'd1, 8'd4, 1'b1},
    {1'b0, 8'd0, 1'b1, 8'd7, 1'b0, 8'd3, 8'd0, 8'd1, 8'd1, 8'd4, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 halted", 32'(halted), 1);
    chk("R1 ring size", 32'(ring_entries), 1024);
    chk("R1 exec_valid", 32'(exec_valid), 0);
    chk("R1 status", status_word, 0);
    chk("R1 err", 32'(err_flag), 0);
    chk("R1 indices", 32'(exec_idx) + 32'(done_ptr) + 32'(post_ptr) + 32'(avail_cnt), 0);

    // ring of 8, engine running
    @(negedge clk);
    size_wr = 1; size_val = 16'd8; halt_wr = 1; halt_val = 0;
    step();
    chk("R3 size 8", 32'(ring_entries), 8);

    // R4 R6 R7 R9 R10 R11 R12 vector walk
    for (int i = 0; i < 15; i++) begin
      logic [59:0] v;
      v = VEC[i];
      @(negedge clk);
      post_wr = v[59]; post_cnt = 16'(v[58:51]);
      free_wr = v[50]; free_cnt = 16'(v[49:42]);
      exec_ready = v[41];
      step();
      chk($sformatf("R4 R6 R12 avail vec%0d", i), 32'(avail_cnt), 32'(v[40:33]));
      chk($sformatf("R6 R7 R11 R12 done vec%0d", i), 32'(status_word[14:0]), 32'(v[32:25]));
      chk($sformatf("R7 R9 done_ptr vec%0d", i), 32'(done_ptr), 32'(v[24:17]));
      chk($sformatf("R6 R9 exec_idx vec%0d", i), 32'(exec_idx), 32'(v[16:9]));
      chk($sformatf("R4 R9 post_ptr vec%0d", i), 32'(post_ptr), 32'(v[8:1]));
      chk($sformatf("R10 R11 err vec%0d", i), 32'(err_flag), 32'(v[0]));
    end

    // R8 status layout: three completions give finished=3, done index 1
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); exec_ready = 1; step();
    end
    chk("R8 status word", status_word, 32'h0001_0003);

    // R5 halt while posting two
    @(negedge clk);
    halt_wr = 1; halt_val = 1; post_wr = 1; post_cnt = 16'd2;
    step();
    chk("R5 halted", 32'(halted), 1);
    chk("R5 avail after post", 32'(avail_cnt), 2);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); exec_ready = 1; step();
      chk("R5 no offer while halted", 32'(exec_valid), 0);
      chk("R5 exec holds", 32'(exec_idx), 4);
    end
    @(negedge clk);
    halt_wr = 1; halt_val = 0; exec_ready = 1;
    step();
    chk("R5 no take on release edge", 32'(exec_idx), 4);
    chk("R5 offer after restart", 32'(exec_valid), 1);
    @(negedge clk); exec_ready = 1; step();
    chk("R5 R6 exec after restart", 32'(exec_idx), 5);
    chk("R6 avail after restart", 32'(avail_cnt), 1);

    // R2 R3 format and size clamping
    @(negedge clk);
    dsz_wr = 1; dsz_val = 3'd1; size_wr = 1; size_val = 16'd20000;
    step();
    chk("R2 small cap", 32'(ring_entries), 16384);
    chk("R3 clear exec", 32'(exec_idx), 0);
    chk("R3 clear status", status_word, 0);
    chk("R3 clear avail", 32'(avail_cnt), 0);
    @(negedge clk); dsz_wr = 1; dsz_val = 3'd7; step();
    chk("R2 large cap", 32'(ring_entries), 4096);
    @(negedge clk); post_wr = 1; post_cnt = 16'd1; step();
    @(negedge clk); dsz_wr = 1; dsz_val = 3'd3; step();
    chk("R2 unknown code size", 32'(ring_entries), 4096);
    chk("R2 unknown code keeps avail", 32'(avail_cnt), 1);
    @(negedge clk); size_wr = 1; size_val = 16'd0; step();
    chk("R3 size floor", 32'(ring_entries), 1);

    // R9 wrap on a one-entry ring
    @(negedge clk); post_wr = 1; post_cnt = 16'd1; step();
    chk("R9 post_ptr wrap", 32'(post_ptr), 0);
    chk("R9 avail", 32'(avail_cnt), 1);
    @(negedge clk); exec_ready = 1; step();
    chk("R9 exec wrap", 32'(exec_idx), 0);
    chk("R9 done count", 32'(status_word[14:0]), 1);
    @(negedge clk); post_wr = 1; post_cnt = 16'd1; step();
    chk("R10 full ring post clamped", 32'(avail_cnt), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule